// File: doc/BRIEF.md
# DRAM Command Timing Guard

The block sits next to a DRAM command scheduler. It keeps a timestamped record of every command that goes out on the command bus. For any candidate command and bank that the scheduler puts on its query port, it answers how many more clock cycles must pass before that command may legally be issued.

The earliest legal cycle is the latest of many pairwise gaps. Some gaps are counted from the same bank and some from the whole rank. On top of those comes a sliding window over the four most recent activates. All gaps are module parameters in clock cycles.

Issue strobes are timestamped by a free-running cycle counter. Each stored timestamp carries its own valid bit. A small state machine tracks how full the activate window is:
- `WIN_EMPTY` moves to `WIN_FILL` on the first activate.
- `WIN_FILL` moves to `WIN_FULL` on the activate that makes the window complete.
- `WIN_FULL` stays put until reset.

The answer is combinational from the stored state and the query inputs. The single exception is the command-bus rule, which also looks at an issue happening in the current cycle.

Top module: `dram_timing_guard`

## Requirements
- R1: The wait output is the largest remaining gap over all applicable constraints, or zero when every constraint is met, and `ready` is 1 exactly when the wait is zero. With no issue in the previous or current cycle and an unchanged query, a nonzero wait falls by exactly one per cycle.
- R2: An activate (code 0) to bank b waits T_RC after the last activate to bank b and T_RRD after the last activate to any bank.
- R3: An activate to bank b waits T_RTP+T_RP after the last read-with-auto-precharge (code 4) to bank b, and T_WL+T_CCD+T_WR+T_RP after the last write-with-auto-precharge (code 6) to bank b.
- R4: An activate waits:
  - T_RP after a precharge (code 1) to its bank, or after any precharge-all (code 2);
  - T_RFC after any refresh-all (code 7);
  - T_XS after a self-refresh exit (code 9);
  - T_XP after a power-down exit (code 8).
- R5: The four most recent activate times are kept. Once four exist, an activate waits until the oldest of them plus T_FAW.
- R6: A read (code 3 or 4) to bank b waits T_RCD after the last activate to bank b, T_CCD after the last read to any bank, and T_WL+T_CCD+T_WTR after the last write to any bank.
- R7: A write (code 5 or 6) to bank b waits T_RCD after the last activate to bank b, T_CCD after the last write to any bank, and T_RL+T_CCD+2-T_WL after the last read to any bank.
- R8: Reads and writes also wait T_XP after a power-down exit and T_XSDLL after a self-refresh exit.
- R9: A precharge to bank b waits T_RAS after the last activate to b, T_RTP after the last read to b, T_WL+T_CCD+T_WR after the last write to b, and T_XP after a power-down exit.
- R10: In a cycle where a known command (codes 0 to 9) is being issued, the wait for every query is at least 1. For queries of codes 2, 7, 8, 9 and 10 to 15, this bus rule is the only constraint.
- R11: A constraint whose reference command has never been issued since reset adds nothing. Per-bank constraints consider only the queried bank.
- R12: Reset clears every stored timestamp and empties the activate window, so every query then reports zero. Issuing reserved codes 10 to 15 records nothing and does not engage the bus rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_vld | input | 1 | A command is issued this cycle |
| iss_cmd | input | 4 | Code of the issued command |
| iss_bank | input | BANK_W | Bank of the issued command |
| qry_cmd | input | 4 | Code of the candidate command |
| qry_bank | input | BANK_W | Bank of the candidate command |
| wait_cycles | output | WAIT_W | Cycles still to wait, saturated to all ones |
| ready | output | 1 | Candidate may issue this cycle |

## Verification
A stale or lost timestamp shows on the very next query of a dependent command: the wait comes out too short or too long by the gap's worth, in the same cycle the query is presented. A wrong activate-window fill state appears only on the fifth and later activates, as a wait set by T_FAW instead of T_RRD. A counter or capture slip turns the steady one-per-cycle countdown of a held query into a jump.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    parameter int unsigned STAMP_W = 32;

    typedef logic [STAMP_W-1:0] stamp_t;

    typedef enum logic [3:0] {
        C_ACT    = 4'd0,
        C_PRE    = 4'd1,
        C_PREALL = 4'd2,
        C_RD     = 4'd3,
        C_RDAP   = 4'd4,
        C_WR     = 4'd5,
        C_WRAP   = 4'd6,
        C_REFALL = 4'd7,
        C_PDX    = 4'd8,
        C_SRX    = 4'd9
    } cmd_e;

    localparam logic [3:0] LAST_CODE = 4'd9;

    // cycles still missing before ts+gap is reached, zero when met or unused
    function automatic stamp_t gap_left(input logic vld, input stamp_t ts,
                                        input stamp_t now, input int unsigned gap);
        stamp_t elapsed;
        stamp_t g;
        elapsed = now - ts;
        g = stamp_t'(gap);
        if (vld && (g > elapsed))
            return g - elapsed;
        return '0;
    endfunction

    function automatic stamp_t stamp_max(input stamp_t a, input stamp_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dtg_stamp_slot.sv
module dtg_stamp_slot
    import dtg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cap,
    input  stamp_t now,
    output logic   vld,
    output stamp_t ts
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= 1'b0;
            ts  <= '0;
        end else if (cap) begin
            vld <= 1'b1;
            ts  <= now;
        end
    end

    a_r11_slot_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (vld && (ts == $past(now))));

endmodule

// File: rtl/dtg_act_window.sv
module dtg_act_window
    import dtg_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push,
    input  stamp_t now,
    output logic   full,
    output stamp_t oldest
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    typedef enum logic [1:0] {
        WIN_EMPTY = 2'd0,
        WIN_FILL  = 2'd1,
        WIN_FULL  = 2'd2
    } win_e;

    win_e             state_q, state_d;
    stamp_t           slot_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] fill_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= WIN_EMPTY;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_EMPTY: if (push) state_d = WIN_FILL;
            WIN_FILL:  if (push && (fill_cnt == LAST_IDX)) state_d = WIN_FULL;
            WIN_FULL:  state_d = WIN_FULL;
            default:   state_d = WIN_EMPTY;
        endcase
    end

    // storage: circular buffer, write pointer lands on the oldest entry once full
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            fill_cnt <= '0;
            for (int i = 0; i < DEPTH; i++)
                slot_q[i] <= '0;
        end else if (push) begin
            slot_q[wr_ptr] <= now;
            wr_ptr         <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (state_q != WIN_FULL)
                fill_cnt <= fill_cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        full   = (state_q == WIN_FULL);
        oldest = slot_q[wr_ptr];
    end

    a_r5_push_leaves_empty: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (state_q != WIN_EMPTY));

    a_r5_hold_without_push: assert property (@(posedge clk) disable iff (!rst_n)
        !push |=> ($stable(oldest) && $stable(full)));

endmodule

// File: rtl/dram_timing_guard.sv
module dram_timing_guard
    import dtg_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 8,
    parameter int unsigned WAIT_W    = 8,
    parameter int unsigned WIN_DEPTH = 4,
    parameter int unsigned T_RCD     = 6,
    parameter int unsigned T_RP      = 6,
    parameter int unsigned T_RAS     = 15,
    parameter int unsigned T_RC      = 21,
    parameter int unsigned T_RRD     = 4,
    parameter int unsigned T_FAW     = 20,
    parameter int unsigned T_CCD     = 4,
    parameter int unsigned T_RTP     = 4,
    parameter int unsigned T_WR      = 6,
    parameter int unsigned T_WTR     = 4,
    parameter int unsigned T_RL      = 6,
    parameter int unsigned T_WL      = 5,
    parameter int unsigned T_RFC     = 44,
    parameter int unsigned T_XS      = 48,
    parameter int unsigned T_XP      = 5,
    parameter int unsigned T_XSDLL   = 64,
    localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_vld,
    input  logic [3:0]        iss_cmd,
    input  logic [BANK_W-1:0] iss_bank,
    input  logic [3:0]        qry_cmd,
    input  logic [BANK_W-1:0] qry_bank,
    output logic [WAIT_W-1:0] wait_cycles,
    output logic              ready
);

    // composed gaps
    localparam int unsigned G_ACT_RDAP = T_RTP + T_RP;
    localparam int unsigned G_ACT_WRAP = T_WL + T_CCD + T_WR + T_RP;
    localparam int unsigned G_RD_WR    = T_WL + T_CCD + T_WTR;
    localparam int unsigned G_WR_RD    = T_RL + T_CCD + 2 - T_WL;
    localparam int unsigned G_PRE_WR   = T_WL + T_CCD + T_WR;

    // per-bank slot kinds
    localparam int unsigned BK_ACT   = 0;
    localparam int unsigned BK_RD    = 1;
    localparam int unsigned BK_WR    = 2;
    localparam int unsigned BK_RDAP  = 3;
    localparam int unsigned BK_WRAP  = 4;
    localparam int unsigned BK_PRE   = 5;
    localparam int unsigned BK_SLOTS = 6;

    // rank-wide slot kinds
    localparam int unsigned GL_ACT    = 0;
    localparam int unsigned GL_RD     = 1;
    localparam int unsigned GL_WR     = 2;
    localparam int unsigned GL_PREALL = 3;
    localparam int unsigned GL_REF    = 4;
    localparam int unsigned GL_PDX    = 5;
    localparam int unsigned GL_SRX    = 6;
    localparam int unsigned GL_SLOTS  = 7;

    localparam stamp_t WAIT_MAX = stamp_t'((1 << WAIT_W) - 1);

    stamp_t now_q;
    logic   issue_known;
    cmd_e   icmd;

    logic   bk_cap [NUM_BANKS][BK_SLOTS];
    logic   bk_vld [NUM_BANKS][BK_SLOTS];
    stamp_t bk_ts  [NUM_BANKS][BK_SLOTS];
    logic   gl_cap [GL_SLOTS];
    logic   gl_vld [GL_SLOTS];
    stamp_t gl_ts  [GL_SLOTS];

    logic   win_full;
    stamp_t win_oldest;
    stamp_t worst;

    // free-running timestamp
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            now_q <= '0;
        else
            now_q <= now_q + 1'b1;
    end

    assign issue_known = iss_vld && (iss_cmd <= LAST_CODE);
    assign icmd        = cmd_e'(iss_cmd);

    // capture enables
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            logic hit;
            hit = issue_known && (iss_bank == BANK_W'(b));
            bk_cap[b][BK_ACT]  = hit && (icmd == C_ACT);
            bk_cap[b][BK_RD]   = hit && ((icmd == C_RD) || (icmd == C_RDAP));
            bk_cap[b][BK_WR]   = hit && ((icmd == C_WR) || (icmd == C_WRAP));
            bk_cap[b][BK_RDAP] = hit && (icmd == C_RDAP);
            bk_cap[b][BK_WRAP] = hit && (icmd == C_WRAP);
            bk_cap[b][BK_PRE]  = hit && (icmd == C_PRE);
        end
        gl_cap[GL_ACT]    = issue_known && (icmd == C_ACT);
        gl_cap[GL_RD]     = issue_known && ((icmd == C_RD) || (icmd == C_RDAP));
        gl_cap[GL_WR]     = issue_known && ((icmd == C_WR) || (icmd == C_WRAP));
        gl_cap[GL_PREALL] = issue_known && (icmd == C_PREALL);
        gl_cap[GL_REF]    = issue_known && (icmd == C_REFALL);
        gl_cap[GL_PDX]    = issue_known && (icmd == C_PDX);
        gl_cap[GL_SRX]    = issue_known && (icmd == C_SRX);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar k = 0; k < BK_SLOTS; k++) begin : g_kind
            dtg_stamp_slot u_slot (
                .clk   (clk),
                .rst_n (rst_n),
                .cap   (bk_cap[b][k]),
                .now   (now_q),
                .vld   (bk_vld[b][k]),
                .ts    (bk_ts[b][k])
            );
        end
    end

    for (genvar g = 0; g < GL_SLOTS; g++) begin : g_rank
        dtg_stamp_slot u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .cap   (gl_cap[g]),
            .now   (now_q),
            .vld   (gl_vld[g]),
            .ts    (gl_ts[g])
        );
    end

    dtg_act_window #(.DEPTH(WIN_DEPTH)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (gl_cap[GL_ACT]),
        .now    (now_q),
        .full   (win_full),
        .oldest (win_oldest)
    );

    // evaluation of the candidate command
    always_comb begin
        stamp_t w;
        w = '0;
        case (qry_cmd)
            C_ACT: begin
                w = stamp_max(w, gap_left(bk_vld[qry_bank][BK_ACT],  bk_ts[qry_bank][BK_ACT],  now_q, T_RC));
                w = stamp_max(w, gap_left(gl_vld[GL_ACT],            gl_ts[GL_ACT],            now_q, T_RRD));
                w = stamp_max(w, gap_left(bk_vld[qry_bank][BK_RDAP], bk_ts[qry_bank][BK_RDAP], now_q, G_ACT_RDAP));
                w = stamp_max(w, gap_left(bk_vld[qry_bank][BK_WRAP], bk_ts[qry_bank][BK_WRAP], now_q, G_ACT_WRAP));
                w = stamp_max(w, gap_left(bk_vld[qry_bank][BK_PRE],  bk_ts[qry_bank][BK_PRE],  now_q, T_RP));
                w = stamp_max(w, gap_left(gl_vld[GL_PREALL],         gl_ts[GL_PREALL],         now_q, T_RP));
                w = stamp_max(w, gap_left(gl_vld[GL_REF],            gl_ts[GL_REF],            now_q, T_RFC));
                w = stamp_max(w, gap_left(gl_vld[GL_SRX],            gl_ts[GL_SRX],            now_q, T_XS));
                w = stamp_max(w, gap_left(gl_vld[GL_PDX],            gl_ts[GL_PDX],            now_q, T_XP));
                w = stamp_max(w, gap_left(win_full,                  win_oldest,               now_q, T_FAW));
            end
            C_RD, C_RDAP: begin
                w = stamp_max(w, gap_left(bk_vld[qry_bank][BK_ACT], bk_ts[qry_bank][BK_ACT], now_q, T_RCD));
                w = stamp_max(w, gap_left(gl_vld[GL_RD],  gl_ts[GL_RD],  now_q, T_CCD));
                w = stamp_max(w, gap_left(gl_vld[GL_WR],  gl_ts[GL_WR],  now_q, G_RD_WR));
                w = stamp_max(w, gap_left(gl_vld[GL_PDX], gl_ts[GL_PDX], now_q, T_XP));
                w = stamp_max(w, gap_left(gl_vld[GL_SRX], gl_ts[GL_SRX], now_q, T_XSDLL));
            end
            C_WR, C_WRAP: begin
                w = stamp_max(w, gap_left(bk_vld[qry_bank][BK_ACT], bk_ts[qry_bank][BK_ACT], now_q, T_RCD));
                w = stamp_max(w, gap_left(gl_vld[GL_WR],  gl_ts[GL_WR],  now_q, T_CCD));
                w = stamp_max(w, gap_left(gl_vld[GL_RD],  gl_ts[GL_RD],  now_q, G_WR_RD));
                w = stamp_max(w, gap_left(gl_vld[GL_PDX], gl_ts[GL_PDX], now_q, T_XP));
                w = stamp_max(w, gap_left(gl_vld[GL_SRX], gl_ts[GL_SRX], now_q, T_XSDLL));
            end
            C_PRE: begin
                w = stamp_max(w, gap_left(bk_vld[qry_bank][BK_ACT], bk_ts[qry_bank][BK_ACT], now_q, T_RAS));
                w = stamp_max(w, gap_left(bk_vld[qry_bank][BK_RD],  bk_ts[qry_bank][BK_RD],  now_q, T_RTP));
                w = stamp_max(w, gap_left(bk_vld[qry_bank][BK_WR],  bk_ts[qry_bank][BK_WR],  now_q, G_PRE_WR));
                w = stamp_max(w, gap_left(gl_vld[GL_PDX], gl_ts[GL_PDX], now_q, T_XP));
            end
            default: ;
        endcase
        if (issue_known)
            w = stamp_max(w, stamp_t'(1));
        worst = w;
    end

    assign wait_cycles = (worst > WAIT_MAX) ? '1 : worst[WAIT_W-1:0];
    assign ready       = (worst == '0);

    a_r1_timestamp_advances: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (now_q == stamp_t'($past(now_q) + 1'b1)));

    a_r1_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!iss_vld && $past(!iss_vld) && $stable(qry_cmd) && $stable(qry_bank) && ($past(wait_cycles) != '0))
        |-> (wait_cycles == $past(wait_cycles) - 1'b1));

    a_r10_bus_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && (iss_cmd <= LAST_CODE)) |-> !ready);

endmodule

// File: tb/dram_timing_guard_test.sv
module dram_timing_guard_test;

    localparam int NB = 8;
    localparam int BW = 3;
    localparam int WW = 8;
    localparam int P_RCD = 6,  P_RP = 6,  P_RAS = 15, P_RC = 21, P_RRD = 4;
    localparam int P_FAW = 20, P_CCD = 4, P_RTP = 4,  P_WR = 6,  P_WTR = 4;
    localparam int P_RL = 6,   P_WL = 5,  P_RFC = 44, P_XS = 48, P_XP = 5, P_XSDLL = 64;

    // command codes as stated in the requirements
    localparam int K_ACT = 0, K_PRE = 1, K_PREALL = 2, K_RD = 3, K_RDAP = 4;
    localparam int K_WR = 5, K_WRAP = 6, K_REF = 7, K_PDX = 8, K_SRX = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_vld = 1'b0;
    logic [3:0]    iss_cmd = '0;
    logic [BW-1:0] iss_bank = '0;
    logic [3:0]    qry_cmd = '0;
    logic [BW-1:0] qry_bank = '0;
    logic [WW-1:0] wait_cycles;
    logic          ready;

    always #5 clk = ~clk;

    dram_timing_guard #(
        .NUM_BANKS(NB), .WAIT_W(WW), .WIN_DEPTH(4),
        .T_RCD(P_RCD), .T_RP(P_RP), .T_RAS(P_RAS), .T_RC(P_RC), .T_RRD(P_RRD),
        .T_FAW(P_FAW), .T_CCD(P_CCD), .T_RTP(P_RTP), .T_WR(P_WR), .T_WTR(P_WTR),
        .T_RL(P_RL), .T_WL(P_WL), .T_RFC(P_RFC), .T_XS(P_XS), .T_XP(P_XP),
        .T_XSDLL(P_XSDLL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_cmd(iss_cmd),
        .iss_bank(iss_bank), .qry_cmd(qry_cmd), .qry_bank(qry_bank),
        .wait_cycles(wait_cycles), .ready(ready)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 0;
    int tnow = 0;
    int last_wait = 0;

    // reference model: absolute issue times per requirement
    int mb_act[NB], mb_rd[NB], mb_wr[NB], mb_rdap[NB], mb_wrap[NB], mb_pre[NB];
    bit vb_act[NB], vb_rd[NB], vb_wr[NB], vb_rdap[NB], vb_wrap[NB], vb_pre[NB];
    int mg_act, mg_rd, mg_wr, mg_preall, mg_ref, mg_pdx, mg_srx;
    bit vg_act, vg_rd, vg_wr, vg_preall, vg_ref, vg_pdx, vg_srx;
    int actq[$];

    task automatic model_clear();
        for (int b = 0; b < NB; b++) begin
            vb_act[b] = 0; vb_rd[b] = 0; vb_wr[b] = 0;
            vb_rdap[b] = 0; vb_wrap[b] = 0; vb_pre[b] = 0;
        end
        vg_act = 0; vg_rd = 0; vg_wr = 0; vg_preall = 0;
        vg_ref = 0; vg_pdx = 0; vg_srx = 0;
        actq.delete();
    endtask

    task automatic model_issue(int c, int b);
        case (c)
            K_ACT: begin
                mb_act[b] = tnow; vb_act[b] = 1; mg_act = tnow; vg_act = 1;
                actq.push_back(tnow);
                if (actq.size() > 4) void'(actq.pop_front());
            end
            K_PRE:    begin mb_pre[b] = tnow; vb_pre[b] = 1; end
            K_PREALL: begin mg_preall = tnow; vg_preall = 1; end
            K_RD, K_RDAP: begin
                mb_rd[b] = tnow; vb_rd[b] = 1; mg_rd = tnow; vg_rd = 1;
                if (c == K_RDAP) begin mb_rdap[b] = tnow; vb_rdap[b] = 1; end
            end
            K_WR, K_WRAP: begin
                mb_wr[b] = tnow; vb_wr[b] = 1; mg_wr = tnow; vg_wr = 1;
                if (c == K_WRAP) begin mb_wrap[b] = tnow; vb_wrap[b] = 1; end
            end
            K_REF: begin mg_ref = tnow; vg_ref = 1; end
            K_PDX: begin mg_pdx = tnow; vg_pdx = 1; end
            K_SRX: begin mg_srx = tnow; vg_srx = 1; end
            default: ;
        endcase
    endtask

    function automatic int lim(int cur, bit v, int t, int g);
        return (v && (t + g > cur)) ? t + g : cur;
    endfunction

    function automatic int exp_wait(int qc, int qb, bit busy);
        int e;
        int w;
        e = tnow;
        case (qc)
            K_ACT: begin
                e = lim(e, vb_act[qb], mb_act[qb], P_RC);
                e = lim(e, vg_act, mg_act, P_RRD);
                e = lim(e, vb_rdap[qb], mb_rdap[qb], P_RTP + P_RP);
                e = lim(e, vb_wrap[qb], mb_wrap[qb], P_WL + P_CCD + P_WR + P_RP);
                e = lim(e, vb_pre[qb], mb_pre[qb], P_RP);
                e = lim(e, vg_preall, mg_preall, P_RP);
                e = lim(e, vg_ref, mg_ref, P_RFC);
                e = lim(e, vg_srx, mg_srx, P_XS);
                e = lim(e, vg_pdx, mg_pdx, P_XP);
                if (actq.size() == 4) e = lim(e, 1'b1, actq[0], P_FAW);
            end
            K_RD, K_RDAP: begin
                e = lim(e, vb_act[qb], mb_act[qb], P_RCD);
                e = lim(e, vg_rd, mg_rd, P_CCD);
                e = lim(e, vg_wr, mg_wr, P_WL + P_CCD + P_WTR);
                e = lim(e, vg_pdx, mg_pdx, P_XP);
                e = lim(e, vg_srx, mg_srx, P_XSDLL);
            end
            K_WR, K_WRAP: begin
                e = lim(e, vb_act[qb], mb_act[qb], P_RCD);
                e = lim(e, vg_wr, mg_wr, P_CCD);
                e = lim(e, vg_rd, mg_rd, P_RL + P_CCD + 2 - P_WL);
                e = lim(e, vg_pdx, mg_pdx, P_XP);
                e = lim(e, vg_srx, mg_srx, P_XSDLL);
            end
            K_PRE: begin
                e = lim(e, vb_act[qb], mb_act[qb], P_RAS);
                e = lim(e, vb_rd[qb], mb_rd[qb], P_RTP);
                e = lim(e, vb_wr[qb], mb_wr[qb], P_WL + P_CCD + P_WR);
                e = lim(e, vg_pdx, mg_pdx, P_XP);
            end
            default: ;
        endcase
        w = e - tnow;
        if (busy && w < 1) w = 1;
        return w;
    endfunction

    task automatic chk(string req, int got, int exp);
        nchk++;
        if (got != exp) begin
            nfail++;
            $display("FAIL %s at t=%0d: got %0d expected %0d", req, tnow, got, exp);
        end
    endtask

    // one cycle: drive on the falling edge, check before the rising edge
    task automatic step(bit iv, int ic, int ib, int qc, int qb, string req);
        int e;
        iss_vld = iv; iss_cmd = 4'(ic); iss_bank = BW'(ib);
        qry_cmd = 4'(qc); qry_bank = BW'(qb);
        #1;
        e = exp_wait(qc, qb, iv && (ic <= 9));
        last_wait = int'(wait_cycles);
        chk(req, int'(wait_cycles), e);
        chk(req, int'(ready), (e == 0) ? 1 : 0);
        @(posedge clk);
        if (iv && (ic <= 9)) model_issue(ic, ib);
        tnow++;
        @(negedge clk);
    endtask

    task automatic do_reset();
        iss_vld = 0;
        rst_n = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        model_clear();
        tnow = 0;
    endtask

    initial begin
        #(10 * 200000);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        int r;
        r = $urandom(32'd4242);
        @(negedge clk);
        do_reset();

        // R12: nothing stored after reset
        for (int q = 0; q < 10; q++) begin
            step(0, 0, 0, q, 0, "R12");
            chk("R12", last_wait, 0);
        end
        // t=10
        step(1, K_ACT, 0, K_ACT, 1, "R10");  chk("R10", last_wait, 1);
        step(0, 0, 0, K_ACT, 0, "R2");       chk("R2", last_wait, 20);
        step(0, 0, 0, K_ACT, 1, "R2");       chk("R2", last_wait, 2);
        step(0, 0, 0, K_RD, 0, "R6");        chk("R6", last_wait, 3);
        step(0, 0, 0, K_RD, 3, "R11");       chk("R11", last_wait, 0);
        step(0, 0, 0, K_PRE, 0, "R9");       chk("R9", last_wait, 10);
        step(1, 12, 0, K_PREALL, 0, "R12");  chk("R12", last_wait, 0);
        step(1, K_RDAP, 5, K_PRE, 2, "R10");
        step(0, 0, 0, K_ACT, 5, "R3");       chk("R3", last_wait, 9);
        step(0, 0, 0, K_WR, 5, "R7");        chk("R7", last_wait, 5);
        step(1, K_PDX, 0, K_REF, 0, "R10");
        step(0, 0, 0, K_RD, 0, "R8");        chk("R8", last_wait, 4);
        step(1, K_REF, 0, K_SRX, 0, "R10");
        step(0, 0, 0, K_ACT, 6, "R4");       chk("R4", last_wait, 43);
        step(1, K_SRX, 0, K_PDX, 0, "R10");
        step(0, 0, 0, K_WR, 0, "R8");        chk("R8", last_wait, 63);
        for (int i = 0; i < 6; i++) step(0, 0, 0, K_WR, 0, "R1");
        chk("R1", last_wait, 57);

        // R12: reset mid-run forgets everything
        do_reset();
        step(0, 0, 0, K_WR, 0, "R12");       chk("R12", last_wait, 0);
        do_reset();
        // R5: four-activate window
        step(1, K_ACT, 0, K_PRE, 7, "R5");
        for (int i = 0; i < 3; i++) step(0, 0, 0, K_PRE, 7, "R5");
        step(1, K_ACT, 1, K_PRE, 7, "R5");
        for (int i = 0; i < 3; i++) step(0, 0, 0, K_PRE, 7, "R5");
        step(1, K_ACT, 2, K_PRE, 7, "R5");
        for (int i = 0; i < 3; i++) step(0, 0, 0, K_PRE, 7, "R5");
        step(1, K_ACT, 3, K_PRE, 7, "R5");
        step(0, 0, 0, K_ACT, 4, "R5");       chk("R5", last_wait, 7);
        for (int i = 0; i < 6; i++) step(0, 0, 0, K_ACT, 4, "R5");
        step(0, 0, 0, K_ACT, 4, "R5");       chk("R5", last_wait, 0);
        step(1, K_PREALL, 0, K_ACT, 4, "R10"); chk("R10", last_wait, 1);
        step(0, 0, 0, K_ACT, 7, "R4");       chk("R4", last_wait, 5);

        // R1: constrained random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            bit iv;
            int ic, ib, qc, qb;
            iv = ($urandom % 3) == 0;
            ic = (($urandom % 8) == 0) ? 10 + ($urandom % 6) : $urandom % 10;
            ib = $urandom % NB;
            qc = $urandom % 12;
            qb = $urandom % NB;
            step(iv, ic, ib, qc, qb, "R1");
        end

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule